// File: doc/BRIEF.md
# Cascadable TDM Audio Serializer

This block turns four 24-bit audio samples per frame into a time-division multiplexed serial stream and lets two such blocks be chained. It runs on a fast system clock. It watches the bit clock and the frame clock as plain inputs and acts on their edges. Each frame it takes the most recently offered set of four samples and sends them one bit per bit-clock period, most significant bit first. Each sample sits in its own 32-bit slot.

The frame is either 128 or 256 bit-clock periods long. In the long frame, a chained arrangement is possible. The upstream block's secondary line carries its four local channels during the first half of the frame. The downstream block captures that stream on its cascade input and stores it. In the second half of the same frame, it replays the stored bits on its primary line. The primary line of the last block in the chain therefore carries eight slots: its own four channels first, then the upstream four. If the cascade input is tied low, the upper four slots carry zeros.

Two frame-alignment conventions are supported. In the left-justified convention, a frame begins on a rising frame-clock edge. In the I2S convention, it begins on a falling edge, one bit later. A power-down input silences both lines and stops framing until the next frame edge.

Top module: `tdm_cascade_serializer`

## Requirements
- R1: Slot k (k = 0..3) carries the sample from `smp_data[24k+23:24k]`: bit 23 goes first, then bits 22 down to 0, then 8 zero bits. Slot k covers frame positions 32k to 32k+31.
- R2: With `fmt_i2s` = 0, a frame starts when `lrck` is 0 at one bit-clock rising edge and 1 at the next. Position 0 appears on the bit-clock falling edge that follows.
- R3: With `fmt_i2s` = 1, a frame starts on a 1-to-0 change of `lrck` seen the same way. One bit period at zero is sent first, and position 0 appears one bit-clock falling edge later than in R2.
- R4: With `tdm256` = 0, the frame has 128 positions. `sdo_sec` stays 0 and `casc_in` has no effect on either output.
- R5: With `tdm256` = 1, `sdo_sec` carries the same four local slots as `sdo_pri` at positions 0..127 and is 0 at positions 128..255.
- R6: With `tdm256` = 1, `casc_in` is sampled on bit-clock rising edges at positions 0..127. Those bits reappear in the same order on `sdo_pri` at positions 128..255 of the same frame, so a low `casc_in` gives zero upper slots.
- R7: Both outputs change only on the system-clock edge at which a bit-clock falling edge is detected, and they are stable across bit-clock rising edges.
- R8: While `pwr_down` is 1, both outputs are 0. After release, output resumes at the next frame start.
- R9: `smp_data` is captured when `smp_valid` is 1 and enters the frame at frame start. If no new capture happens, the previous words are sent again.
- R10: After `rst`, both outputs are 0 until the first frame start is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | 1 silences outputs and stops framing |
| bick | input | 1 | Bit clock, synchronous to `clk` |
| lrck | input | 1 | Frame clock, changes on bit-clock falling edges |
| tdm256 | input | 1 | 1: 256-position frame with cascade; 0: 128-position frame |
| fmt_i2s | input | 1 | 1: I2S alignment; 0: left-justified |
| smp_valid | input | 1 | Capture strobe for `smp_data` |
| smp_data | input | 96 | Four samples, slot k in bits 24k+23..24k |
| casc_in | input | 1 | Serial stream from the upstream block |
| sdo_pri | output | 1 | Primary serial line |
| sdo_sec | output | 1 | Secondary serial line (local stream for chaining) |

## Verification
Two events can land on the same system-clock edge. The first is the bit-clock falling edge that sends position 128. The second is the last cascade capture at position 127, which happened on the rising edge just before, together with the switch from local data to buffered data. The bench drives an upstream stream whose slot boundaries are aligned with that switch and compares every primary bit of the second half against the upstream words, so a shift or off-by-one in the buffer shows up at once. A second collision comes from power-down being released right before a frame edge. The first frame afterwards must come out whole.

// File: rtl/tdm_cas_pkg.sv
package tdm_cas_pkg;

    localparam int SLOT_BITS  = 32;
    localparam int SMP_BITS   = 24;
    localparam int N_CH       = 4;
    localparam int WORDS_W    = N_CH * SMP_BITS;
    localparam int HALF_BITS  = N_CH * SLOT_BITS;
    localparam int FULL_BITS  = 2 * HALF_BITS;
    localparam int HALF_IDX_W = $clog2(HALF_BITS);
    localparam int POS_W      = $clog2(FULL_BITS) + 2;

    // Position codes: IDLE parks the counter past any frame, LEAD is the
    // single silent bit that precedes position 0 in the I2S alignment.
    localparam logic [POS_W-1:0] POS_HALF = POS_W'(HALF_BITS);
    localparam logic [POS_W-1:0] POS_FULL = POS_W'(FULL_BITS);
    localparam logic [POS_W-1:0] POS_IDLE = POS_W'(2 * FULL_BITS);
    localparam logic [POS_W-1:0] POS_LEAD = '1;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sync;
    } bick_ev_t;

    // Bit of the local four-slot stream at a given frame position.
    function automatic logic local_bit(input logic [WORDS_W-1:0] w,
                                       input logic [POS_W-1:0]   p);
        int unsigned pi;
        int unsigned ch;
        int unsigned bi;
        pi = 32'(p);
        if (pi >= HALF_BITS) return 1'b0;
        ch = pi / SLOT_BITS;
        bi = pi % SLOT_BITS;
        if (bi >= SMP_BITS) return 1'b0;
        return w[ch * SMP_BITS + (SMP_BITS - 1 - bi)];
    endfunction

endpackage

// File: rtl/tdm_cas_edges.sv
module tdm_cas_edges
    import tdm_cas_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_down,
    input  logic     bick,
    input  logic     lrck,
    input  logic     fmt_i2s,
    output bick_ev_t ev
);

    logic bick_q;
    logic lrck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            bick_q <= 1'b0;
        end else begin
            bick_q <= bick;
        end
    end

    // Frame clock level as seen at the last bit-clock rising edge.
    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            lrck_s <= 1'b0;
        end else if (ev.rise) begin
            lrck_s <= lrck;
        end
    end

    always_comb begin
        ev.rise = bick & ~bick_q;
        ev.fall = ~bick & bick_q;
        ev.sync = ev.rise & ~pwr_down &
                  (fmt_i2s ? (lrck_s & ~lrck) : (~lrck_s & lrck));
    end

endmodule

// File: rtl/tdm_cas_timer.sv
module tdm_cas_timer
    import tdm_cas_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_down,
    input  bick_ev_t           ev,
    input  logic               fmt_i2s,
    input  logic [WORDS_W-1:0] hold_words,
    output logic [POS_W-1:0]   pos_q,
    output logic [POS_W-1:0]   pos_nxt,
    output logic [WORDS_W-1:0] words_nxt,
    output logic               pend_q
);

    logic [WORDS_W-1:0] words_q;

    // Look-ahead of the position and frame words the next falling edge brings.
    always_comb begin
        pos_nxt   = pos_q;
        words_nxt = words_q;
        if (ev.fall) begin
            if (pend_q) begin
                pos_nxt   = fmt_i2s ? POS_LEAD : '0;
                words_nxt = hold_words;
            end else if (pos_q != POS_IDLE) begin
                pos_nxt = pos_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            pos_q   <= POS_IDLE;
            words_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            pos_q   <= pos_nxt;
            words_q <= words_nxt;
            if (ev.sync) begin
                pend_q <= 1'b1;
            end else if (ev.fall) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tdm_cas_chain_buf.sv
module tdm_cas_chain_buf
    import tdm_cas_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_down,
    input  logic                  shift_en,
    input  logic                  cin,
    input  logic [HALF_IDX_W-1:0] rd_sel,
    output logic                  rd_bit
);

    logic [HALF_BITS-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            buf_q <= '0;
        end else if (shift_en) begin
            buf_q <= {buf_q[HALF_BITS-2:0], cin};
        end
    end

    // The oldest bit sits at the top; HALF_BITS is a power of two, so the
    // index HALF_BITS-1-rd_sel is the bitwise inverse of rd_sel.
    assign rd_bit = buf_q[~rd_sel];

endmodule

// File: rtl/tdm_cascade_serializer.sv
module tdm_cascade_serializer
    import tdm_cas_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_down,
    input  logic        bick,
    input  logic        lrck,
    input  logic        tdm256,
    input  logic        fmt_i2s,
    input  logic        smp_valid,
    input  logic [95:0] smp_data,
    input  logic        casc_in,
    output logic        sdo_pri,
    output logic        sdo_sec
);

    bick_ev_t           ev;
    logic [WORDS_W-1:0] hold_q;
    logic [POS_W-1:0]   pos_q;
    logic [POS_W-1:0]   pos_nxt;
    logic [WORDS_W-1:0] words_nxt;
    logic               pend_q;
    logic               bick_fall;
    logic               cap_en;
    logic               buf_bit;
    logic               loc_bit;
    logic               upper_half;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (smp_valid) begin
            hold_q <= smp_data;
        end
    end

    tdm_cas_edges u_edges (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .bick     (bick),
        .lrck     (lrck),
        .fmt_i2s  (fmt_i2s),
        .ev       (ev)
    );

    tdm_cas_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .pwr_down   (pwr_down),
        .ev         (ev),
        .fmt_i2s    (fmt_i2s),
        .hold_words (hold_q),
        .pos_q      (pos_q),
        .pos_nxt    (pos_nxt),
        .words_nxt  (words_nxt),
        .pend_q     (pend_q)
    );

    assign bick_fall = ev.fall;
    assign cap_en    = tdm256 & ev.rise & (pos_q < POS_HALF);

    tdm_cas_chain_buf u_chain (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .shift_en (cap_en),
        .cin      (casc_in),
        .rd_sel   (pos_nxt[HALF_IDX_W-1:0]),
        .rd_bit   (buf_bit)
    );

    assign loc_bit    = local_bit(words_nxt, pos_nxt);
    assign upper_half = tdm256 & (pos_nxt >= POS_HALF) & (pos_nxt < POS_FULL);

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            sdo_pri <= 1'b0;
            sdo_sec <= 1'b0;
        end else if (ev.fall) begin
            sdo_pri <= loc_bit | (upper_half & buf_bit);
            sdo_sec <= tdm256 & loc_bit;
        end
    end

endmodule

// File: rtl/tdm_cas_checker.sv
module tdm_cas_checker
    import tdm_cas_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pwr_down,
    input logic             bick,
    input logic             tdm256,
    input logic             fmt_i2s,
    input logic             sdo_pri,
    input logic             sdo_sec,
    input logic [POS_W-1:0] pos_q,
    input logic             pend_q,
    input logic             bick_fall
);

    // R7: an output moves only right after a detected bit-clock falling edge
    p_pri_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdo_pri) && !$past(pwr_down)) |-> ($past(bick) == 1'b0 && $past(bick, 2) == 1'b1));

    p_sec_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdo_sec) && !$past(pwr_down)) |-> ($past(bick) == 1'b0 && $past(bick, 2) == 1'b1));

    // R4: the short frame never drives the secondary line
    p_sec_quiet_short_r4: assert property (@(posedge clk) disable iff (rst)
        (!tdm256 && bick_fall) |=> !sdo_sec);

    // R5: the secondary line is low in the second half of a long frame
    p_sec_upper_low_r5: assert property (@(posedge clk) disable iff (rst)
        (pos_q >= POS_HALF) |-> !sdo_sec);

    // R8: power-down silences both lines
    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!sdo_pri && !sdo_sec));

    // R2: left-justified start lands on position 0
    p_start_left_r2: assert property (@(posedge clk) disable iff (rst)
        (pend_q && bick_fall && !pwr_down && !fmt_i2s) |=> (pos_q == '0));

    // R3: I2S start inserts the lead bit first
    p_start_i2s_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_q && bick_fall && !pwr_down && fmt_i2s) |=> (pos_q == POS_LEAD));

endmodule

bind tdm_cascade_serializer tdm_cas_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_down  (pwr_down),
    .bick      (bick),
    .tdm256    (tdm256),
    .fmt_i2s   (fmt_i2s),
    .sdo_pri   (sdo_pri),
    .sdo_sec   (sdo_sec),
    .pos_q     (pos_q),
    .pend_q    (pend_q),
    .bick_fall (bick_fall)
);

// File: tb/tdm_cascade_serializer_bench.sv
module tdm_cascade_serializer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_down = 1'b0;
    logic        bick = 1'b0;
    logic        lrck = 1'b0;
    logic        tdm256 = 1'b1;
    logic        fmt_i2s = 1'b0;
    logic        smp_valid = 1'b0;
    logic [95:0] smp_data = '0;
    logic        casc_in = 1'b0;
    logic        sdo_pri;
    logic        sdo_sec;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tdm_cascade_serializer u_tdm_cascade_serializer (
        .clk       (clk),
        .rst       (rst),
        .pwr_down  (pwr_down),
        .bick      (bick),
        .lrck      (lrck),
        .tdm256    (tdm256),
        .fmt_i2s   (fmt_i2s),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .casc_in   (casc_in),
        .sdo_pri   (sdo_pri),
        .sdo_sec   (sdo_sec)
    );

    function automatic logic [23:0] wgen(input int f, input int ch, input int seed);
        logic [31:0] x;
        x = 32'(seed) * 32'h9E3779B1 ^ 32'(f) * 32'h85EBCA6B ^ 32'(ch + 1) * 32'hC2B2AE35;
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 13);
        return x[23:0];
    endfunction

    function automatic logic slot_bit(input logic [23:0] w [4], input int b);
        if (b >= 128 || b % 32 >= 24) return 1'b0;
        return w[b / 32][23 - (b % 32)];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp_v,
                       input string what, input int f, input int b);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s %s frame %0d pos %0d: actual %b expected %b",
                     req, what, f, b, act, exp_v);
        end
    endtask

    // Runs nfr frames. cmode: 0 casc low, 1 upstream stream, 2 noise.
    // hold_frame: frame in which no new words are offered.
    // pd_frame: frame held in power-down (released 3 bits before its end).
    task automatic run_frames(input bit m256, input bit i2s, input int nfr,
                              input int cmode, input int hold_frame,
                              input int pd_frame, input int seed, input string tag);
        int frame_len;
        int sync_at;
        logic [23:0] cur [4];
        logic [23:0] nxt [4];
        logic [23:0] up [4];
        logic ep, es, ap, as_;
        frame_len = m256 ? 256 : 128;
        sync_at = frame_len - 1 - int'(i2s);
        tdm256 = m256;
        fmt_i2s = i2s;
        for (int k = 0; k < 4; k++) begin
            cur[k] = '0;
            nxt[k] = '0;
        end
        for (int f = 0; f < nfr; f++) begin
            for (int k = 0; k < 4; k++) up[k] = wgen(f, k, seed + 100);
            for (int b = 0; b < frame_len; b++) begin
                @(negedge clk);
                bick = 1'b0;
                lrck = ((((b - sync_at) + frame_len) % frame_len) < 4) ^ i2s;
                if (cmode == 1)      casc_in = slot_bit(up, b);
                else if (cmode == 2) casc_in = ((b * 5 + f * 3) % 7) < 3;
                else                 casc_in = 1'b0;
                if (f == pd_frame) pwr_down = (b < frame_len - 3);
                if (b == 64 && f != hold_frame) begin
                    for (int k = 0; k < 4; k++) begin
                        nxt[k] = wgen(f + 1, k, seed);
                        smp_data[24 * k +: 24] = nxt[k];
                    end
                    smp_valid = 1'b1;
                end
                @(negedge clk);
                smp_valid = 1'b0;
                ap = sdo_pri;
                as_ = sdo_sec;
                if (f >= 1) begin
                    if (f == pd_frame) begin
                        chk("R8", ap, 1'b0, "pri", f, b);
                        chk("R8", as_, 1'b0, "sec", f, b);
                    end else begin
                        ep = slot_bit(cur, b);
                        if (m256 && b >= 128 && cmode == 1) ep = ep | slot_bit(up, b - 128);
                        es = m256 ? slot_bit(cur, b) : 1'b0;
                        chk(tag, ap, ep, "pri", f, b);
                        chk(tag, as_, es, "sec", f, b);
                    end
                end
                @(negedge clk);
                bick = 1'b1;
                @(negedge clk);
                if (f >= 1) begin
                    chk("R7", sdo_pri, ap, "pri held over rise", f, b);
                    chk("R7", sdo_sec, as_, "sec held over rise", f, b);
                end
            end
            for (int k = 0; k < 4; k++) cur[k] = nxt[k];
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        lrck = 1'b0;
        fmt_i2s = 1'b0;
        for (int b = 0; b < 8; b++) begin
            @(negedge clk); bick = 1'b0;
            @(negedge clk);
            chk("R10", sdo_pri, 1'b0, "pri after reset", 0, b);
            chk("R10", sdo_sec, 1'b0, "sec after reset", 0, b);
            @(negedge clk); bick = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic test_long_left();   run_frames(1'b1, 1'b0, 3, 1, -1, -1, 11, "R1/R2/R5/R6"); endtask
    task automatic test_long_i2s();    run_frames(1'b1, 1'b1, 3, 1, -1, -1, 23, "R3/R5/R6");    endtask
    task automatic test_short_left();  run_frames(1'b0, 1'b0, 3, 2, -1, -1, 37, "R4/R2");       endtask
    task automatic test_short_i2s();   run_frames(1'b0, 1'b1, 3, 2, -1, -1, 41, "R4/R3");       endtask
    task automatic test_hold_words();  run_frames(1'b1, 1'b0, 4, 1,  1, -1, 53, "R9");          endtask
    task automatic test_casc_low();    run_frames(1'b1, 1'b1, 3, 0, -1, -1, 67, "R6");          endtask
    task automatic test_power_down();  run_frames(1'b1, 1'b0, 4, 1, -1,  1, 79, "R8");          endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_long_left();
        test_long_i2s();
        test_short_left();
        test_short_i2s();
        test_hold_words();
        test_casc_low();
        test_power_down();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule